// File: doc/BRIEF.md
# Hypervisor Interrupt Pending and Enable Registers

This block keeps the three interrupt registers that a hypervisor uses to steer interrupts towards a virtual supervisor: a virtual-pending register that software sets to inject interrupts, a pending register that merges software, timer and external sources, and an enable register. Software reaches all three through a plain register port made of an address, a write strobe, write data and combinational read data.

The pending register is mostly derived. Its external bit merges the software-injected request, the guest-external source picked by a guest-select field and a platform external line. Its guest-external bit reports whether any guest-external source is both pending and enabled. Its timer bit merges the injected request with a timer input. Only the software bit can be written through the pending register, and it shares its storage with the virtual-pending register. The effective pending and enable vectors go straight to the trap logic.

Top module: `hyp_irq_regs`

## Requirements
- R1: While rst_ni is low, and right after it rises, the virtual-pending and enable registers hold zero, so eff_en_o reads 0 and eff_pend_o carries only the input-driven bits.
- R2: In the pending and enable vectors only bit 2 (VS software), bit 6 (VS timer), bit 10 (VS external) and bit 12 (guest external) can be nonzero. In the virtual-pending register only bits 2, 6 and 10 can be nonzero. Every other bit reads 0.
- R3: A write to the virtual-pending register (address 0x645) stores wdata bits 2, 6 and 10. From the next clock edge the stored value reads back, and each set bit raises the same bit of eff_pend_o.
- R4: Pending bit 12 is 1 exactly when some guest index k from 1 to GUEST_CNT has both gext_pend_i[k] and gext_en_i[k] set. Index 0 of both vectors is ignored.
- R5: Pending bit 10 is the OR of virtual-pending bit 10, vs_ext_irq_i and gext_pend_i[guest_sel_i]. The last term counts only when guest_sel_i is between 1 and GUEST_CNT. Any other select value contributes 0.
- R6: Pending bit 6 is the OR of virtual-pending bit 6 and vs_timer_irq_i. A write to the pending register does not change it.
- R7: A write to the pending register (address 0x644) copies wdata bit 2 into virtual-pending bit 2, so writing 0 there clears the injected software interrupt. All other wdata bits of that write have no effect.
- R8: A write to the enable register (address 0x604) stores wdata bits 2, 6, 10 and 12. From the next edge, eff_en_o and the read data show that value.
- R9: Read data is the value before any write in the same cycle. An address matching none of the three registers reads 0.
- R10: A write to any other address, or any cycle with csr_we_i low, leaves both stored registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | ADDR_W | Register address |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for the addressed register |
| gext_pend_i | input | GUEST_CNT+1 | Guest-external pending vector, index 0 unused |
| gext_en_i | input | GUEST_CNT+1 | Guest-external enable vector, index 0 unused |
| guest_sel_i | input | SEL_W | Guest index that feeds the VS external bit |
| vs_ext_irq_i | input | 1 | Platform VS external interrupt |
| vs_timer_irq_i | input | 1 | VS timer interrupt source |
| eff_pend_o | output | XLEN | Effective pending vector |
| eff_en_o | output | XLEN | Effective enable vector |

## Verification
A register write and a register read can fall in the same cycle. The case that matters is a write to the pending register that clears the shared software bit, or a write to the enable register, while the same address is being read. The bench holds the write strobe high and samples the read data before the edge, where it must still show the old value, then samples after the edge for the new value. The composite pending bits can also change in the very cycle a write lands, so the bench sweeps guest select, guest patterns and the external line with the injected bit both set and clear, and checks each merge against a sum computed in the bench.

// File: rtl/hyp_irq_pkg.sv
package hyp_irq_pkg;
  localparam int unsigned VSSI_BIT = 2;
  localparam int unsigned VSTI_BIT = 6;
  localparam int unsigned VSEI_BIT = 10;
  localparam int unsigned SGEI_BIT = 12;

  localparam logic [15:0] VIRT_MASK16  = 16'h0444;
  localparam logic [15:0] PEND_MASK16  = 16'h1444;
  localparam logic [15:0] ALIAS_MASK16 = 16'h0004;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_VIRT,
    SEL_PEND,
    SEL_EN
  } csr_sel_e;
endpackage

// File: rtl/hyp_csr_decode.sv
module hyp_csr_decode
  import hyp_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ADDR_VIRT = 'h645,
  parameter int unsigned ADDR_PEND = 'h644,
  parameter int unsigned ADDR_EN   = 'h604
) (
  input  logic [ADDR_W-1:0] addr_i,
  output csr_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(ADDR_VIRT))      sel_o = SEL_VIRT;
    else if (addr_i == ADDR_W'(ADDR_PEND)) sel_o = SEL_PEND;
    else if (addr_i == ADDR_W'(ADDR_EN))   sel_o = SEL_EN;
    else                                   sel_o = SEL_NONE;
  end
endmodule

// File: rtl/hyp_guest_sel.sv
module hyp_guest_sel #(
  parameter int unsigned GUEST_CNT = 8,
  parameter int unsigned SEL_W     = 6
) (
  input  logic [GUEST_CNT:0] pend_i,
  input  logic [GUEST_CNT:0] en_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               sel_hit_o,
  output logic               any_o
);
  logic [GUEST_CNT:0] hit;
  logic [GUEST_CNT:0] act;
  logic               unused_idx0;

  // index 0 is never a guest
  assign hit[0] = 1'b0;
  assign act[0] = 1'b0;
  assign unused_idx0 = pend_i[0] ^ en_i[0];

  for (genvar g = 1; g <= GUEST_CNT; g++) begin : g_guest
    assign hit[g] = pend_i[g] && (sel_i == SEL_W'(g));
    assign act[g] = pend_i[g] && en_i[g];
  end

  assign sel_hit_o = |hit;
  assign any_o     = |act;
endmodule

// File: rtl/hyp_mask_reg.sv
module hyp_mask_reg #(
  parameter int unsigned XLEN   = 32,
  parameter logic [15:0] MASK_A = 16'h0000,
  parameter logic [15:0] MASK_B = 16'h0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_a_i,
  input  logic            wr_b_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] q_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign q_o[XLEN-1:16] = '0;

  for (genvar b = 0; b < 16; b++) begin : g_bit
    localparam bit IN_A = MASK_A[b];
    localparam bit IN_B = MASK_B[b];
    if (IN_A || IN_B) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              bit_q <= 1'b0;
        else if (wr_a_i && IN_A)  bit_q <= wdata_i[b];
        else if (wr_b_i && IN_B)  bit_q <= wdata_i[b];
      end
      assign q_o[b] = bit_q;
    end else begin : g_zero
      assign q_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/hyp_irq_regs.sv
module hyp_irq_regs
  import hyp_irq_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned GUEST_CNT = 8,
  parameter int unsigned SEL_W     = 6,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ADDR_VIRT = 'h645,
  parameter int unsigned ADDR_PEND = 'h644,
  parameter int unsigned ADDR_EN   = 'h604
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    csr_addr_i,
  input  logic                 csr_we_i,
  input  logic [XLEN-1:0]      csr_wdata_i,
  output logic [XLEN-1:0]      csr_rdata_o,
  input  logic [GUEST_CNT:0]   gext_pend_i,
  input  logic [GUEST_CNT:0]   gext_en_i,
  input  logic [SEL_W-1:0]     guest_sel_i,
  input  logic                 vs_ext_irq_i,
  input  logic                 vs_timer_irq_i,
  output logic [XLEN-1:0]      eff_pend_o,
  output logic [XLEN-1:0]      eff_en_o
);
  csr_sel_e        sel;
  logic            wr_virt, wr_pend, wr_en;
  logic [XLEN-1:0] vip_q, en_q, pend_w;
  logic            sel_hit, gext_any;

  hyp_csr_decode #(
    .ADDR_W(ADDR_W), .ADDR_VIRT(ADDR_VIRT),
    .ADDR_PEND(ADDR_PEND), .ADDR_EN(ADDR_EN)
  ) u_dec (
    .addr_i(csr_addr_i),
    .sel_o (sel)
  );

  assign wr_virt = csr_we_i && (sel == SEL_VIRT);
  assign wr_pend = csr_we_i && (sel == SEL_PEND);
  assign wr_en   = csr_we_i && (sel == SEL_EN);

  // port B: software bit written through the pending register
  hyp_mask_reg #(
    .XLEN(XLEN), .MASK_A(VIRT_MASK16), .MASK_B(ALIAS_MASK16)
  ) u_vip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_a_i (wr_virt),
    .wr_b_i (wr_pend),
    .wdata_i(csr_wdata_i),
    .q_o    (vip_q)
  );

  hyp_mask_reg #(
    .XLEN(XLEN), .MASK_A(PEND_MASK16), .MASK_B(16'h0000)
  ) u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_a_i (wr_en),
    .wr_b_i (1'b0),
    .wdata_i(csr_wdata_i),
    .q_o    (en_q)
  );

  hyp_guest_sel #(
    .GUEST_CNT(GUEST_CNT), .SEL_W(SEL_W)
  ) u_gsel (
    .pend_i   (gext_pend_i),
    .en_i     (gext_en_i),
    .sel_i    (guest_sel_i),
    .sel_hit_o(sel_hit),
    .any_o    (gext_any)
  );

  always_comb begin
    pend_w           = '0;
    pend_w[VSSI_BIT] = vip_q[VSSI_BIT];
    pend_w[VSTI_BIT] = vip_q[VSTI_BIT] | vs_timer_irq_i;
    pend_w[VSEI_BIT] = vip_q[VSEI_BIT] | sel_hit | vs_ext_irq_i;
    pend_w[SGEI_BIT] = gext_any;
  end

  always_comb begin
    unique case (sel)
      SEL_VIRT: csr_rdata_o = vip_q;
      SEL_PEND: csr_rdata_o = pend_w;
      SEL_EN:   csr_rdata_o = en_q;
      default:  csr_rdata_o = '0;
    endcase
  end

  assign eff_pend_o = pend_w;
  assign eff_en_o   = en_q;
endmodule

// File: rtl/hyp_irq_regs_chk.sv
module hyp_irq_regs_chk
  import hyp_irq_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned GUEST_CNT = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ADDR_VIRT = 'h645,
  parameter int unsigned ADDR_PEND = 'h644,
  parameter int unsigned ADDR_EN   = 'h604
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   csr_addr_i,
  input logic                csr_we_i,
  input logic [XLEN-1:0]     csr_wdata_i,
  input logic [GUEST_CNT:0]  gext_pend_i,
  input logic [GUEST_CNT:0]  gext_en_i,
  input logic                vs_ext_irq_i,
  input logic                vs_timer_irq_i,
  input logic [XLEN-1:0]     eff_pend_o,
  input logic [XLEN-1:0]     eff_en_o
);
  localparam logic [XLEN-1:0] PMASK = XLEN'(PEND_MASK16);
  localparam logic [GUEST_CNT:0] GMASK = ~(GUEST_CNT+1)'(1);

  assert_pend_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_pend_o & ~PMASK) == '0);
  assert_en_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_en_o & ~PMASK) == '0);
  assert_vip_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == ADDR_W'(ADDR_VIRT) && csr_wdata_i[VSEI_BIT])
    |=> eff_pend_o[VSEI_BIT]);
  assert_sgei_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(gext_pend_i & gext_en_i & GMASK)) |-> eff_pend_o[SGEI_BIT]);
  assert_vsei_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_ext_irq_i |-> eff_pend_o[VSEI_BIT]);
  assert_vsti_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_timer_irq_i |-> eff_pend_o[VSTI_BIT]);
  assert_alias_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == ADDR_W'(ADDR_PEND))
    |=> eff_pend_o[VSSI_BIT] == $past(csr_wdata_i[VSSI_BIT]));
  assert_en_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == ADDR_W'(ADDR_EN))
    |=> eff_en_o == ($past(csr_wdata_i) & PMASK));
  assert_en_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_we_i |=> $stable(eff_en_o));
endmodule

bind hyp_irq_regs hyp_irq_regs_chk #(
  .XLEN(XLEN), .GUEST_CNT(GUEST_CNT), .ADDR_W(ADDR_W),
  .ADDR_VIRT(ADDR_VIRT), .ADDR_PEND(ADDR_PEND), .ADDR_EN(ADDR_EN)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_addr_i    (csr_addr_i),
  .csr_we_i      (csr_we_i),
  .csr_wdata_i   (csr_wdata_i),
  .gext_pend_i   (gext_pend_i),
  .gext_en_i     (gext_en_i),
  .vs_ext_irq_i  (vs_ext_irq_i),
  .vs_timer_irq_i(vs_timer_irq_i),
  .eff_pend_o    (eff_pend_o),
  .eff_en_o      (eff_en_o)
);

// File: tb/hyp_irq_regs_tb_top.sv
module hyp_irq_regs_tb_top;
  localparam int GC = 8;
  localparam logic [11:0] A_VIRT = 12'h645;
  localparam logic [11:0] A_PEND = 12'h644;
  localparam logic [11:0] A_EN   = 12'h604;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [GC:0] gpend = '0;
  logic [GC:0] gen = '0;
  logic [5:0]  gsel = '0;
  logic        vext = 1'b0;
  logic        vtim = 1'b0;
  logic [31:0] epend, een;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  hyp_irq_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_we_i(we),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .gext_pend_i(gpend),
    .gext_en_i(gen), .guest_sel_i(gsel), .vs_ext_irq_i(vext),
    .vs_timer_irq_i(vtim), .eff_pend_o(epend), .eff_en_o(een)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_VIRT, v); chk("R1 virt after reset", v, 32'h0);
    rd(A_EN, v);   chk("R1 en after reset", v, 32'h0);
    rd(A_PEND, v); chk("R1 pend after reset", v, 32'h0);
    chk("R1 eff_en after reset", een, 32'h0);

    // R3/R2 virtual-pending writes
    for (int i = 0; i < 32; i++) begin
      logic [31:0] d;
      d = 32'h9E3779B9 * (i + 1) ^ (32'h1 << i);
      wr(A_VIRT, d);
      rd(A_VIRT, v); chk("R3 virt readback", v, d & 32'h0444);
      chk("R2 R3 eff_pend", epend, d & 32'h0444);
    end
    wr(A_VIRT, 32'hFFFF_FFFF);
    rd(A_VIRT, v); chk("R2 virt all ones", v, 32'h0444);
    wr(A_VIRT, 32'h0);

    // R4 guest-external sweep
    for (int e = 0; e < 4; e++) begin
      logic [GC:0] ev;
      ev = (e == 0) ? 9'h1FF : (e == 1) ? 9'h0AA : (e == 2) ? 9'h155 : 9'h001;
      for (int p = 0; p < 512; p++) begin
        logic [31:0] exp;
        gen = ev; gpend = p[GC:0];
        #1;
        exp = ((p[GC:0] & ev & 9'h1FE) != 0) ? 32'h1000 : 32'h0;
        chk("R4 guest external bit", epend, exp);
      end
    end
    gpend = '0; gen = '0;

    // R5 external merge sweep
    for (int h = 0; h < 2; h++) begin
      wr(A_VIRT, (h != 0) ? 32'h400 : 32'h0);
      for (int x = 0; x < 2; x++) begin
        for (int s = 0; s < 64; s++) begin
          for (int q = 0; q < 4; q++) begin
            logic [GC:0] pv;
            logic hitb;
            pv = (q == 0) ? 9'h000 : (q == 1) ? 9'h1FE : (q == 2) ? 9'h0AA : 9'h155;
            gpend = pv; gsel = s[5:0]; vext = x[0];
            #1;
            hitb = (s >= 1 && s <= GC) ? pv[s] : 1'b0;
            chk("R5 VS external bit", {21'h0, epend[10], 10'h0},
                {21'h0, (h != 0) | (x != 0) | hitb, 10'h0});
          end
        end
      end
    end
    gpend = '0; gsel = '0; vext = 1'b0;
    wr(A_VIRT, 32'h0);

    // R6 timer merge, not writable through pending register
    for (int h = 0; h < 2; h++) begin
      wr(A_VIRT, (h != 0) ? 32'h40 : 32'h0);
      for (int t = 0; t < 2; t++) begin
        vtim = t[0]; #1;
        chk("R6 VS timer bit", epend & 32'h40, ((h | t) != 0) ? 32'h40 : 32'h0);
      end
    end
    vtim = 1'b0;
    wr(A_VIRT, 32'h0);
    wr(A_PEND, 32'h40);
    chk("R6 pend write ignored on timer", epend, 32'h0);

    // R7 alias of software bit
    wr(A_VIRT, 32'h0);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_VIRT, v); chk("R7 alias set virt", v, 32'h0004);
    rd(A_PEND, v); chk("R7 alias pend view", v, 32'h0004);
    wr(A_VIRT, 32'h0444);
    wr(A_PEND, 32'h0);
    rd(A_VIRT, v); chk("R7 alias clear keeps others", v, 32'h0440);

    // R8 enable writes
    for (int i = 0; i < 32; i++) begin
      logic [31:0] d;
      d = 32'h7F4A7C15 * (i + 3) ^ (32'h1 << i);
      wr(A_EN, d);
      rd(A_EN, v); chk("R8 en readback", v, d & 32'h1444);
      chk("R8 R2 eff_en", een, d & 32'h1444);
    end

    // R9 read before write, same cycle
    wr(A_EN, 32'h1000);
    @(negedge clk);
    addr = A_EN; we = 1'b1; wdata = 32'h0044;
    #1; chk("R9 read old en during write", rdata, 32'h1000);
    @(negedge clk); we = 1'b0; #1;
    chk("R9 read new en after write", rdata, 32'h0044);
    wr(A_VIRT, 32'h4);
    @(negedge clk);
    addr = A_PEND; we = 1'b1; wdata = 32'h0;
    #1; chk("R9 read old pend during clear", rdata & 32'h4, 32'h4);
    @(negedge clk); we = 1'b0; #1;
    chk("R9 read pend after clear", rdata & 32'h4, 32'h0);
    rd(12'h000, v); chk("R9 unmapped read", v, 32'h0);
    rd(12'h646, v); chk("R9 unmapped read near", v, 32'h0);

    // R10 no effect of stray writes
    wr(A_VIRT, 32'h0440);
    wr(A_EN, 32'h1004);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h605, 32'h0);
    @(negedge clk); addr = A_EN; wdata = 32'h0; we = 1'b0;
    @(negedge clk);
    rd(A_VIRT, v); chk("R10 virt unchanged", v, 32'h0440);
    rd(A_EN, v);   chk("R10 en unchanged", v, 32'h1004);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 en cleared by reset", een, 32'h0);
    chk("R1 pend cleared by reset", epend, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(A_VIRT, v); chk("R1 virt after reset release", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule